// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a 12-bit successive-approximation converter whose serial clock also paces its conversion. A one-cycle start request makes the block pull the active-low select line down. That falling edge is the converter's sampling instant. The block then toggles a serial clock, derived from the system clock by a fixed divider, for exactly sixteen periods. It captures one bit on every falling edge it drives, and then releases the select line.

Each frame carries four bits that must read zero, followed by a twos-complement result with the most significant bit first. The block sign-extends that result to the output width and marks it with a one-cycle valid pulse. It raises an error flag when any of the four lead bits reads one, and still outputs the data word in that case. Between frames the select line stays high for a minimum gap. A request that arrives during a frame or during the gap is held, and it launches the next frame as soon as the gap ends.

Top module: `sar_readout`

## Requirements
- R1: After reset the select line and the serial clock are high, and the valid strobe, the result and the error flag are all zero.
- R2: The serial clock does not change while the select line is high. Its first falling edge comes DIV_HALF system cycles after the select line falls.
- R3: Each frame holds exactly FRAME_BITS (16) falling serial clock edges. Every high and low phase lasts DIV_HALF system cycles.
- R4: The serial data input is captured at each falling edge the block drives, most significant bit first. The last DATA_BITS (12) captured bits form the result.
- R5: The result is the captured 12-bit twos-complement code sign-extended to OUT_BITS: code 0x800 gives 0xF800 and code 0x7FF gives 0x07FF.
- R6: The valid strobe is high for exactly one cycle, on the system edge that drives the sixteenth falling serial clock edge. The result does not change at any other time.
- R7: The error flag is updated with every valid strobe. It is one exactly when any of the first four captured bits is one, and the data word is output either way.
- R8: The select line rises DIV_HALF cycles after the sixteenth falling edge, together with the serial clock rising, and the valid strobe comes while the select line is still low.
- R9: Between frames the select line stays high for at least QUIET_CYC cycles. A held request starts the next frame exactly QUIET_CYC cycles after the select line rose, including a request that arrives in the last cycle of the gap.
- R10: Any number of start requests during one frame cause exactly one further frame.
- R11: A start request seen while idle pulls the select line low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request for one frame |
| adcSdata | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Active-low select, starts sampling and frames the read |
| adcSclk | output | 1 | Serial clock, idles high |
| result | output | OUT_BITS | Sign-extended conversion result |
| resultValid | output | 1 | One-cycle strobe for a new result |
| frameErr | output | 1 | A lead bit of the last frame read as one |

## Verification
The block can release a held request and take in a fresh one on the same cycle: the last cycle of the quiet gap, when the gap counter expires and the start input is also high. The bench finds the cycle where the select line rose and drives a request exactly QUIET_CYC-1 cycles later. It then judges that the select line falls on the following edge with a gap of exactly QUIET_CYC, and that exactly one further frame is read. In the same way, the result register loads on the same edge that drives the last falling serial clock edge, and the bench checks that the valid strobe and that edge fall in the same cycle.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_QUIET = 2'd3
  } rdState_t;

  typedef struct packed {
    logic clear;
    logic sample;
    logic last;
  } dpStrobe_t;

endpackage

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_readout_pkg::*;
#(
  parameter int DIV_HALF   = 5,
  parameter int QUIET_CYC  = 6,
  parameter int FRAME_BITS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output logic      csN,
  output logic      sclk,
  output dpStrobe_t strobe
);

  localparam int CNT_MAX = (DIV_HALF > QUIET_CYC) ? DIV_HALF : QUIET_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] QUIET_LOAD = CNT_W'(QUIET_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_IDX   = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] FULL_IDX   = BIT_W'(FRAME_BITS);

  rdState_t          stateQ, stateN;
  logic [CNT_W-1:0]  cntQ, cntN;
  logic [BIT_W-1:0]  bitQ, bitN;
  logic              pendQ, pendN;
  logic              csQ, csNxt;
  logic              sclkQ, sclkNxt;
  logic              want;
  logic              cntZero;

  assign want    = startReq | pendQ;
  assign cntZero = (cntQ == '0);

  always_comb begin
    stateN  = stateQ;
    cntN    = cntQ;
    bitN    = bitQ;
    csNxt   = csQ;
    sclkNxt = sclkQ;
    pendN   = (stateQ == ST_IDLE) ? 1'b0 : (pendQ | startReq);
    strobe  = '0;

    case (stateQ)
      ST_IDLE: begin
        if (want) begin
          stateN       = ST_SETUP;
          csNxt        = 1'b0;
          cntN         = HALF_LOAD;
          bitN         = '0;
          pendN        = 1'b0;
          strobe.clear = 1'b1;
        end
      end

      ST_SETUP: begin
        if (cntZero) begin
          stateN        = ST_SHIFT;
          sclkNxt       = 1'b0;
          strobe.sample = 1'b1;
          strobe.last   = (bitQ == LAST_IDX);
          bitN          = bitQ + 1'b1;
          cntN          = HALF_LOAD;
        end else begin
          cntN = cntQ - 1'b1;
        end
      end

      ST_SHIFT: begin
        if (!cntZero) begin
          cntN = cntQ - 1'b1;
        end else if (sclkQ) begin
          // falling edge: the converter output is still stable here
          sclkNxt       = 1'b0;
          strobe.sample = 1'b1;
          strobe.last   = (bitQ == LAST_IDX);
          bitN          = bitQ + 1'b1;
          cntN          = HALF_LOAD;
        end else begin
          sclkNxt = 1'b1;
          if (bitQ == FULL_IDX) begin
            stateN = ST_QUIET;
            csNxt  = 1'b1;
            cntN   = QUIET_LOAD;
          end else begin
            cntN = HALF_LOAD;
          end
        end
      end

      default: begin
        if (!cntZero) begin
          cntN = cntQ - 1'b1;
        end else if (want) begin
          stateN       = ST_SETUP;
          csNxt        = 1'b0;
          cntN         = HALF_LOAD;
          bitN         = '0;
          pendN        = 1'b0;
          strobe.clear = 1'b1;
        end else begin
          stateN = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
      pendQ  <= 1'b0;
      csQ    <= 1'b1;
      sclkQ  <= 1'b1;
    end else begin
      stateQ <= stateN;
      cntQ   <= cntN;
      bitQ   <= bitN;
      pendQ  <= pendN;
      csQ    <= csNxt;
      sclkQ  <= sclkNxt;
    end
  end

  assign csN  = csQ;
  assign sclk = sclkQ;

endmodule

// File: rtl/sar_readout_dp.sv
module sar_readout_dp
  import sar_readout_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int LEAD_BITS  = 4,
  parameter int OUT_BITS   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdata,
  input  dpStrobe_t           strobe,
  output logic [OUT_BITS-1:0] result,
  output logic                resultValid,
  output logic                frameErr
);

  localparam int DATA_BITS = FRAME_BITS - LEAD_BITS;
  localparam int EXT_BITS  = OUT_BITS - DATA_BITS;

  logic [FRAME_BITS-2:0] shiftQ;
  logic [FRAME_BITS-1:0] word;
  logic [OUT_BITS-1:0]   extended;
  logic                  leadBad;
  logic [OUT_BITS-1:0]   resultQ;
  logic                  validQ;
  logic                  errQ;

  assign word    = {shiftQ, sdata};
  assign leadBad = |word[FRAME_BITS-1:DATA_BITS];

  generate
    if (EXT_BITS > 0) begin : g_ext
      assign extended = {{EXT_BITS{word[DATA_BITS-1]}}, word[DATA_BITS-1:0]};
    end else begin : g_noext
      assign extended = word[OUT_BITS-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      resultQ <= '0;
      validQ  <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      validQ <= strobe.sample & strobe.last;
      if (strobe.clear) begin
        shiftQ <= '0;
      end else if (strobe.sample) begin
        shiftQ <= word[FRAME_BITS-2:0];
      end
      if (strobe.sample && strobe.last) begin
        resultQ <= extended;
        errQ    <= leadBad;
      end
    end
  end

  assign result      = resultQ;
  assign resultValid = validQ;
  assign frameErr    = errQ;

endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_readout_pkg::*;
#(
  parameter int DIV_HALF   = 5,
  parameter int QUIET_CYC  = 6,
  parameter int FRAME_BITS = 16,
  parameter int LEAD_BITS  = 4,
  parameter int OUT_BITS   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                adcSdata,
  output logic                adcCsN,
  output logic                adcSclk,
  output logic [OUT_BITS-1:0] result,
  output logic                resultValid,
  output logic                frameErr
);

  dpStrobe_t strobe;

  sar_readout_ctrl #(
    .DIV_HALF  (DIV_HALF),
    .QUIET_CYC (QUIET_CYC),
    .FRAME_BITS(FRAME_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .csN     (adcCsN),
    .sclk    (adcSclk),
    .strobe  (strobe)
  );

  sar_readout_dp #(
    .FRAME_BITS(FRAME_BITS),
    .LEAD_BITS (LEAD_BITS),
    .OUT_BITS  (OUT_BITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sdata      (adcSdata),
    .strobe     (strobe),
    .result     (result),
    .resultValid(resultValid),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int QUIET_CYC  = 6,
  parameter int FRAME_BITS = 16,
  parameter int OUT_BITS   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                adcCsN,
  input logic                adcSclk,
  input logic [OUT_BITS-1:0] result,
  input logic                resultValid,
  input logic                frameErr
);

  localparam int FC_W = $clog2(FRAME_BITS + 2);
  localparam int HC_W = $clog2(QUIET_CYC + 1);

  logic            sclkD;
  logic            csD;
  logic [FC_W-1:0] fallCnt;
  logic [HC_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD   <= 1'b1;
      csD     <= 1'b1;
      fallCnt <= '0;
      highCnt <= HC_W'(QUIET_CYC);
    end else begin
      sclkD <= adcSclk;
      csD   <= adcCsN;
      if (csD && !adcCsN) begin
        fallCnt <= '0;
      end else if (!adcCsN && sclkD && !adcSclk) begin
        fallCnt <= fallCnt + 1'b1;
      end
      if (!adcCsN) begin
        highCnt <= '0;
      end else if (highCnt != HC_W'(QUIET_CYC)) begin
        highCnt <= highCnt + 1'b1;
      end
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> adcSclk);

  assert_cs_fall_sclk_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> adcSclk);

  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCsN) |-> (fallCnt == FC_W'(FRAME_BITS)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  assert_err_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(frameErr));

  assert_valid_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !adcCsN);

  assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> (highCnt >= HC_W'(QUIET_CYC)));

endmodule

bind sar_readout sar_readout_chk #(
  .QUIET_CYC (QUIET_CYC),
  .FRAME_BITS(FRAME_BITS),
  .OUT_BITS  (OUT_BITS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .adcCsN     (adcCsN),
  .adcSclk    (adcSclk),
  .result     (result),
  .resultValid(resultValid),
  .frameErr   (frameErr)
);

// File: tb/sar_readout_tb_top.sv
`timescale 1ns/1ps
module sar_readout_tb_top;

  localparam int DIV_HALF  = 5;
  localparam int QUIET_CYC = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        adcSdata = 1'b0;
  logic        adcCsN;
  logic        adcSclk;
  logic [15:0] result;
  logic        resultValid;
  logic        frameErr;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sar_readout #(.DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .adcSdata(adcSdata),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .result(result),
    .resultValid(resultValid), .frameErr(frameErr)
  );

  // converter model: first bit on select fall, next bit after each falling clock
  logic [15:0] adcWord = 16'h0;
  int idx = 0;
  always @(negedge adcCsN or negedge adcSclk) begin
    if (!adcCsN && adcSclk) begin
      idx = 0;
      adcSdata = adcWord[15];
    end else if (!adcCsN) begin
      #2;
      idx++;
      adcSdata = (idx < 16) ? adcWord[15 - idx] : 1'b0;
    end
  end

  // observer, sampled away from the active edge
  int cyc = 0, tCsFall = 0, tCsRise = -100, tLastFall = 0, tFirstFall = 0, lastEdge = 0;
  int falls = 0, badHalf = 0, idleEdges = 0, validCnt = 0, frames = 0, tValid = 0;
  int longValid = 0, lastGap = 0;
  logic prevCs = 1'b1, prevSclk = 1'b1, prevValid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (prevCs && !adcCsN) begin
      lastGap = cyc - tCsRise; tCsFall = cyc; falls = 0; badHalf = 0;
      lastEdge = cyc; frames++;
    end
    if (prevSclk != adcSclk) begin
      if (prevCs) idleEdges++;
      else begin
        if (cyc - lastEdge != DIV_HALF) badHalf++;
        lastEdge = cyc;
        if (!adcSclk) begin
          falls++;
          tLastFall = cyc;
          if (falls == 1) tFirstFall = cyc;
        end
      end
    end
    if (!prevCs && adcCsN) tCsRise = cyc;
    if (resultValid) begin
      validCnt++; tValid = cyc;
      if (prevValid) longValid++;
    end
    prevCs = adcCsN; prevSclk = adcSclk; prevValid = resultValid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(input logic [15:0] w);
    return {{4{w[11]}}, w[11:0]};
  endfunction

  task automatic wait_valid(input int v0);
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (validCnt > v0) break;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 csN", adcCsN, 1); check("R1 sclk", adcSclk, 1);
    check("R1 valid", resultValid, 0); check("R1 result", result, 0);
    check("R1 err", frameErr, 0);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    check("R2 idle sclk", adcSclk, 1);
    check("R2 idle edges", idleEdges, 0);
  endtask

  task automatic run_frame(input string tag, input logic [15:0] w);
    int v0;
    v0 = validCnt;
    adcWord = w;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check({tag, " R11 select low next edge"}, adcCsN, 0);
    wait_valid(v0);
    @(negedge clk);
    check({tag, " R4 R5 result"}, result, sext(w));
    check({tag, " R7 error flag"}, frameErr, (w[15:12] != 0));
    repeat (DIV_HALF + QUIET_CYC + 4) @(negedge clk);
    check({tag, " R3 falls"}, falls, 16);
    check({tag, " R3 half widths"}, badHalf, 0);
    check({tag, " R2 setup"}, tFirstFall - tCsFall, DIV_HALF);
    check({tag, " R6 valid on last fall"}, tValid, tLastFall);
    check({tag, " R6 one valid"}, validCnt - v0, 1);
    check({tag, " R8 release"}, tCsRise - tLastFall, DIV_HALF);
    check({tag, " R6 result held"}, result, sext(w));
  endtask

  task automatic test_back_to_back();
    int v0, f0;
    v0 = validCnt; f0 = frames;
    adcWord = 16'h0321;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    pulse_start();
    wait_valid(v0);
    adcWord = 16'h0C0F;
    @(negedge clk);
    check("R4 first of pair", result, 16'h0321);
    wait_valid(v0 + 1);
    @(negedge clk);
    check("R9 held gap", lastGap, QUIET_CYC);
    check("R5 second of pair", result, 16'hFC0F);
    repeat (400) @(negedge clk);
    check("R10 frames", frames - f0, 2);
    check("R10 valids", validCnt - v0, 2);
  endtask

  task automatic test_last_quiet_cycle();
    int v0, f0;
    v0 = validCnt; f0 = frames;
    adcWord = 16'h0123;
    pulse_start();
    wait_valid(v0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (adcCsN) break;
    end
    repeat (QUIET_CYC - 1) @(negedge clk);
    adcWord = 16'h0FFE;
    startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R9 launch at gap end", adcCsN, 0);
    wait_valid(v0 + 1);
    @(negedge clk);
    check("R9 gap length", lastGap, QUIET_CYC);
    check("R5 minus two", result, 16'hFFFE);
    repeat (300) @(negedge clk);
    check("R10 one extra", frames - f0, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_frame("max", 16'h07FF);
    run_frame("min", 16'h0800);
    run_frame("zero", 16'h0000);
    run_frame("alt1", 16'h0555);
    run_frame("alt2", 16'h0AAA);
    run_frame("lead err", 16'h9123);
    run_frame("err clear", 16'h0456);
    run_frame("one lead", 16'h1FFF);
    test_back_to_back();
    test_last_quiet_cycle();
    check("R6 no stretched valid", longValid, 0);
    check("R2 no idle edges", idleEdges, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule